// File: doc/BRIEF.md
# Link Pulse Burst Receiver

This block turns a stream of single-cycle link pulse events into 16-bit link code words. A burst consists of framing pulses at a steady spacing. Between each pair of framing pulses there may be one data pulse. The receiver measures the time since the most recent framing pulse and sorts each arriving pulse by that time. A pulse near half the framing period is a data pulse. A pulse near the full framing period is a framing pulse. Any other pulse is malformed.

Each interval between framing pulses gives one bit. The bit is 1 if a data pulse arrived in that interval and 0 if none did. The receiver waits for the seventeenth framing pulse. It then presents the finished word for one cycle together with a valid strobe. A burst that breaks any timing rule, or that stops before its seventeenth framing pulse, raises a one-cycle error strobe instead. The partial word is discarded, so the negotiation logic above this block can restart.

The framing period, the two tolerance windows and the silence timeout are parameters. The default values suit a small bench configuration. In a real design they would be scaled to the clock rate.

Top module: `lpb_rx`

## Requirements
- R1: While reset is asserted and after it is released, `word_o` is 0, and `word_vld_o` and `err_o` are low until a complete burst or a fault occurs.
- R2: While no burst is in progress, any pulse starts a new burst as its first framing pulse. This also applies to the first pulse after an error or after a completed word.
- R3: A pulse that arrives D cycles after the latest framing pulse is a data pulse when HALF-DTOL <= D <= HALF+DTOL, where HALF is PERIOD/2. A data pulse sets the bit of its interval to 1. An interval with no data pulse gives 0.
- R4: A pulse that arrives D cycles after the latest framing pulse is a framing pulse when PERIOD-FTOL <= D <= PERIOD+FTOL. It closes the current bit interval.
- R5: The bit from the interval after framing pulse k (k = 1..16) is placed at `word_o[k-1]`. The 5-bit selector, which is the first five bits of the burst, therefore appears at `word_o[4:0]`.
- R6: When the seventeenth framing pulse is sampled at a clock edge, the receiver does two things at that same edge. It loads `word_o` with the assembled word, and it raises `word_vld_o` for exactly one cycle.
- R7: If TIMEOUT cycles pass after a framing pulse with no further framing pulse, `err_o` pulses high for one cycle and the burst is abandoned. The error appears at the edge where the gap reaches TIMEOUT. TIMEOUT is larger than PERIOD+FTOL.
- R8: A second data pulse inside one framing interval raises `err_o` for one cycle at the edge that samples that pulse, and the burst is abandoned.
- R9: A pulse at any gap outside both the data window and the framing window raises `err_o` for one cycle at the edge that samples it. The pulse is consumed, the burst is abandoned, and `word_vld_o` is never high in the same cycle as `err_o`.
- R10: An abandoned burst leaves `word_o` unchanged. `word_o` changes only in a cycle where `word_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | 1 | One-cycle link pulse event |
| word_o | output | 16 | Last completed link code word, bit 0 first received |
| word_vld_o | output | 1 | One-cycle strobe: `word_o` has just been loaded |
| err_o | output | 1 | One-cycle strobe: malformed or incomplete burst |

## Verification
The bench sweeps the gap of the second pulse across every value from 1 to TIMEOUT. This exposes an off-by-one at any of the four window edges: a receiver with one would accept a pulse it should reject, or report an error for a valid burst. Framing and data gaps are also varied within their tolerances while one-hot and walking-zero words are sent. A design that shifted bits in from the wrong end, or lost the last interval's bit, would show a mirrored or truncated word. Dedicated bursts check the exact cycle of the timeout error, a doubled data pulse, and that the previous word survives an abandoned burst. A receiver that let a partial word leak to the output, or that fired the timeout one cycle early or late, would be caught by these.

// File: rtl/lpb_rx.sv
module lpb_rx #(
  parameter int PERIOD  = 20,
  parameter int DTOL    = 3,
  parameter int FTOL    = 3,
  parameter int TIMEOUT = 30,
  parameter int WBITS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  output logic [WBITS-1:0] word_o,
  output logic             word_vld_o,
  output logic             err_o
);
  localparam int HALF = PERIOD / 2;
  localparam int GW   = $clog2(TIMEOUT + 1);
  localparam int NW   = $clog2(WBITS + 2);
  localparam logic [GW-1:0] D_LO = GW'(HALF - DTOL);
  localparam logic [GW-1:0] D_HI = GW'(HALF + DTOL);
  localparam logic [GW-1:0] F_LO = GW'(PERIOD - FTOL);
  localparam logic [GW-1:0] F_HI = GW'(PERIOD + FTOL);
  localparam logic [GW-1:0] T_LIM = GW'(TIMEOUT);

  logic             active;
  logic [GW-1:0]    gap;
  logic [NW-1:0]    nfr;
  logic             got_data;
  logic [WBITS-1:0] shreg;

  logic in_data, in_frame, frame_ok, data_ok, bad, last;
  logic [WBITS-1:0] next_word;

  assign in_data   = (gap >= D_LO) && (gap <= D_HI);
  assign in_frame  = (gap >= F_LO) && (gap <= F_HI);
  assign frame_ok  = active && pulse_i && in_frame;
  assign data_ok   = active && pulse_i && in_data && !got_data;
  assign bad       = active && ((pulse_i && !in_frame && !data_ok) ||
                                (!pulse_i && gap >= T_LIM));
  assign last      = frame_ok && (nfr == NW'(WBITS));
  assign next_word = {got_data, shreg[WBITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      gap        <= '0;
      nfr        <= '0;
      got_data   <= 1'b0;
      shreg      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      word_vld_o <= last;
      err_o      <= bad;
      if (!active) begin
        if (pulse_i) begin
          active   <= 1'b1;
          gap      <= GW'(1);
          nfr      <= NW'(1);
          got_data <= 1'b0;
        end
      end else if (bad) begin
        active <= 1'b0;
      end else if (frame_ok) begin
        shreg    <= next_word;
        got_data <= 1'b0;
        gap      <= GW'(1);
        nfr      <= nfr + NW'(1);
        if (last) begin
          active <= 1'b0;
          word_o <= next_word;
        end
      end else begin
        if (data_ok) got_data <= 1'b1;
        gap <= gap + GW'(1);
      end
    end
  end
endmodule

// File: rtl/lpb_rx_chk.sv
module lpb_rx_chk #(
  parameter int WBITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pulse_i,
  input logic [WBITS-1:0] word_o,
  input logic             word_vld_o,
  input logic             err_o
);
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o); // R6
  AST_VLD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> $past(pulse_i)); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R7
  AST_VLD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld_o && err_o)); // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o)); // R10
endmodule

bind lpb_rx lpb_rx_chk #(.WBITS(WBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i),
  .word_o(word_o), .word_vld_o(word_vld_o), .err_o(err_o)
);

// File: tb/lpb_rx_tb.sv
`timescale 1ns/1ps
module lpb_rx_tb;
  localparam int PERIOD = 20, DTOL = 3, FTOL = 3, TIMEOUT = 30, WBITS = 16;
  localparam int HALF = PERIOD / 2;

  logic clk = 1'b0, rst_n = 1'b0, pulse_i = 1'b0;
  logic [WBITS-1:0] word_o;
  logic word_vld_o, err_o;
  int n_run = 0, n_fail = 0, nv = 0, ne = 0;
  bit vld_now, err_now;

  always #10 clk = ~clk;

  lpb_rx #(.PERIOD(PERIOD), .DTOL(DTOL), .FTOL(FTOL), .TIMEOUT(TIMEOUT), .WBITS(WBITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i),
    .word_o(word_o), .word_vld_o(word_vld_o), .err_o(err_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit p);
    pulse_i = p;
    @(posedge clk);
    @(negedge clk);
    vld_now = word_vld_o;
    err_now = err_o;
    if (word_vld_o) nv++;
    if (err_o) ne++;
  endtask

  task automatic pulse_at(input int d);
    repeat (d - 1) step(1'b0);
    step(1'b1);
  endtask

  function automatic int fgap(input int k);
    return PERIOD + (k * 3) % (2 * FTOL + 1) - FTOL;
  endfunction

  function automatic int dgap(input int k);
    return HALF + (k * 5) % (2 * DTOL + 1) - DTOL;
  endfunction

  task automatic send_word(input logic [WBITS-1:0] w, input int v, input string req);
    int ne0;
    ne0 = ne;
    step(1'b1);
    for (int k = 0; k < WBITS; k++) begin
      if (w[k]) begin
        pulse_at(dgap(k + v));
        pulse_at(fgap(k + v) - dgap(k + v));
      end else begin
        pulse_at(fgap(k + v));
      end
    end
    chk(vld_now, "R6", "valid after 17th framing pulse", int'(vld_now), 1);
    chk(word_o == w, req, "received word", int'(word_o), int'(w));
    chk(ne == ne0, "R4", "errors during valid burst", ne - ne0, 0);
    step(1'b0);
    chk(!vld_now, "R6", "valid lasts one cycle", int'(vld_now), 0);
    repeat (3) step(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(word_o == '0 && !word_vld_o && !err_o, "R1", "outputs in reset", int'(word_o), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0);
    chk(!vld_now && !err_now && word_o == '0, "R1", "idle after reset", int'(err_now), 0);

    for (int b = 0; b < WBITS; b++) send_word(WBITS'(1) << b, b, "R3");
    for (int b = 0; b < WBITS; b++) send_word(~(WBITS'(1) << b), b + 7, "R5");
    send_word('0, 1, "R3");
    send_word('1, 2, "R3");
    send_word(16'h0001, 3, "R5");
    chk(word_o[4:0] == 5'b00001, "R5", "selector in low bits", int'(word_o[4:0]), 1);

    for (int d = 1; d <= TIMEOUT; d++) begin
      int nv0;
      nv0 = nv;
      step(1'b1);
      pulse_at(d);
      if (d >= HALF - DTOL && d <= HALF + DTOL) begin
        pulse_at(PERIOD - d);
        repeat (WBITS - 1) pulse_at(PERIOD);
        chk(vld_now && word_o == 16'h0001, "R3", $sformatf("data gap %0d", d), int'(word_o), 1);
      end else if (d >= PERIOD - FTOL && d <= PERIOD + FTOL) begin
        repeat (WBITS - 1) pulse_at(PERIOD);
        chk(vld_now && word_o == 16'h0000, "R4", $sformatf("framing gap %0d", d), int'(word_o), 0);
      end else begin
        chk(err_now && !vld_now, "R9", $sformatf("stray gap %0d error", d), int'(err_now), 1);
        repeat (3) step(1'b0);
        chk(nv == nv0, "R9", "no word after stray pulse", nv - nv0, 0);
      end
      repeat (3) step(1'b0);
    end

    send_word(16'hA5C3, 4, "R2");
    begin
      int cnt;
      cnt = 0;
      step(1'b1);
      repeat (3) pulse_at(PERIOD);
      for (int i = 1; i <= TIMEOUT + 5; i++) begin
        step(1'b0);
        if (err_now && cnt == 0) cnt = i;
      end
      chk(cnt == TIMEOUT, "R7", "timeout error cycle", cnt, TIMEOUT);
      chk(word_o == 16'hA5C3, "R10", "word kept after timeout", int'(word_o), 'hA5C3);
    end

    step(1'b1);
    pulse_at(HALF);
    pulse_at(1);
    chk(err_now, "R8", "second data pulse error", int'(err_now), 1);
    repeat (PERIOD * 2) step(1'b0);
    chk(word_o == 16'hA5C3, "R10", "word kept after double data", int'(word_o), 'hA5C3);

    step(1'b1);
    pulse_at(PERIOD + FTOL + 1);
    chk(err_now, "R9", "late framing pulse error", int'(err_now), 1);
    repeat (3) step(1'b0);
    send_word(16'h3C5A, 5, "R2");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule